// File: doc/BRIEF.md
# Prescaled Clock Timer with Coherent Nibble Readout

This block keeps low-frequency time from a 32768 Hz oscillator clock. A fixed divide-by-128 prescaler runs while a clock-enable bit is set. It gives one tick every 128 oscillator cycles, so the tick rate is 256 Hz. An 8-bit binary counter advances on each tick while the run bit is set. Counter bit 0 toggles at 128 Hz, bit 1 at 64 Hz, and so on up to bit 7, which toggles at 1 Hz.

Software reads the counter through a 4-bit bus, one nibble at a time. A read of the low nibble also copies the upper four counter bits into a holding register. A read of the high nibble returns that copy. Software reads low first and then high, and the two nibbles form one consistent byte even if a carry into the upper half happens between the two reads.

A control register sets clock enable, run and interrupt enable. Writing that register with a clear bit resets the count. A one-cycle interrupt request marks each wrap of the counter from 255 to 0, which happens once per second.

Top module: `rtcn_timer`

## Requirements
- R1: The prescaler advances only while the clock-enable bit is 1 (control register, address 2, bit 0). When it is set and run is set, the counter increments once every 128 oscillator cycles, on the edge where the prescaler wraps from 127 to 0. While the bit is 0 the count does not change.
- R2: When the run bit (address 2, bit 1) is 0, the counter holds its value while the prescaler keeps running. Setting the bit back to 1 resumes counting from the held value.
- R3: A write to address 2 with bit 3 set clears the counter and the prescaler on that edge. The clear wins over an increment on the same edge. Bits 2:0 are stored as usual. Bit 3 reads back as 0. The holding register is not changed.
- R4: A read of address 0 returns counter bits 3:0 on busRdata[3:0] in the same cycle. On the edge where busRd is high and the address is 0, the holding register loads counter bits 7:4.
- R5: A read of address 1 always returns the holding register and never the live counter bits 7:4. The holding register keeps its value until the next read of address 0.
- R6: A read of address 2 returns {0, irqEnable, run, clockEnable} on bits 3:0. A read of address 3 returns 0. After reset all registers are 0 and irqReq is 0.
- R7: irqReq is high for exactly one cycle, the cycle after the counter wraps from 255 to 0 by counting. It does so only while the interrupt-enable bit (address 2, bit 2) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address: 0 low nibble, 1 held high nibble, 2 control, 3 unused |
| busRd | input | 1 | Read strobe; together with address 0 it loads the holding register |
| busWr | input | 1 | Write strobe; only address 2 is writable |
| busWdata | input | 4 | Write data: bit 0 clock enable, bit 1 run, bit 2 interrupt enable, bit 3 clear |
| busRdata | output | 4 | Read data, combinational on busAddr |
| irqReq | output | 1 | One-cycle interrupt request on each counter wrap |

## Verification
The hardest case to reach is a carry from bit 3 into bit 4 that falls between a low read and the following high read. The high read must then show the old upper nibble, while the live counter already holds the new value. The bench waits, using its own tick model, until the count is 0x0F. It reads the low nibble there. It then waits for the tick to 0x10 and reads the high nibble, which must still be 0. A second low read then moves the new value into the holding register. Interrupts need a full 256-tick wrap, so the bench waits through one wrap with interrupts disabled and one with them enabled.

// File: rtl/rtcn_pkg.sv
package rtcn_pkg;
  // strobes handed from the control block to the datapath
  typedef struct packed {
    logic prescStep;  // prescaler may advance this cycle
    logic cntRun;     // counter may take a tick
    logic clrAll;     // clear counter and prescaler
    logic latchHi;    // capture upper counter nibble
    logic irqArm;     // interrupt enable
  } tmrStrobe_t;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/rtcn_ctrl.sv
module rtcn_ctrl
  import rtcn_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busRd,
  input  logic             busWr,
  input  logic [NIB_W-1:0] busWdata,
  input  logic [NIB_W-1:0] lowNib,
  input  logic [NIB_W-1:0] holdNib,
  output logic [NIB_W-1:0] busRdata,
  output tmrStrobe_t       strobe
);
  logic clkEn, runEn, irqEn;
  logic ctrlWr;

  assign ctrlWr = busWr && (busAddr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkEn <= 1'b0;
      runEn <= 1'b0;
      irqEn <= 1'b0;
    end else if (ctrlWr) begin
      clkEn <= busWdata[0];
      runEn <= busWdata[1];
      irqEn <= busWdata[2];
    end
  end

  always_comb begin
    strobe.prescStep = clkEn;
    strobe.cntRun    = runEn;
    strobe.clrAll    = ctrlWr && busWdata[3];
    strobe.latchHi   = busRd && (busAddr == ADDR_LO);
    strobe.irqArm    = irqEn;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_LO:   busRdata = lowNib;
      ADDR_HI:   busRdata = holdNib;
      ADDR_CTRL: busRdata[2:0] = {irqEn, runEn, clkEn};
      default:   busRdata = '0;
    endcase
  end

  // R3: the clear bit is a strobe and never shows in the readback
  a_r3_clear_not_stored: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_CTRL) |-> (busRdata[NIB_W-1] == 1'b0));
  // R6: unused address reads zero
  a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> (busRdata == '0));
endmodule

// File: rtl/rtcn_datapath.sv
module rtcn_datapath
  import rtcn_pkg::*;
#(
  parameter int PRESC_W = 7,
  parameter int CNT_W   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tmrStrobe_t             strobe,
  output logic [CNT_W/2-1:0]     lowNib,
  output logic [CNT_W/2-1:0]     holdNib,
  output logic                   irqReq
);
  localparam int NIB_W = CNT_W / 2;
  localparam logic [PRESC_W-1:0] PRESC_MAX = {PRESC_W{1'b1}};
  localparam logic [CNT_W-1:0]   CNT_MAX   = {CNT_W{1'b1}};

  logic [PRESC_W-1:0] presc;
  logic [CNT_W-1:0]   cnt;
  logic [NIB_W-1:0]   hold;
  logic               irqQ;
  logic               tick, adv;

  assign tick = strobe.prescStep && (presc == PRESC_MAX);
  assign adv  = tick && strobe.cntRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc <= '0;
      cnt   <= '0;
    end else if (strobe.clrAll) begin
      presc <= '0;
      cnt   <= '0;
    end else begin
      if (strobe.prescStep) presc <= presc + 1'b1;
      if (adv)              cnt   <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               hold <= '0;
    else if (strobe.latchHi) hold <= cnt[CNT_W-1 -: NIB_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= strobe.irqArm && adv && !strobe.clrAll && (cnt == CNT_MAX);
  end

  assign lowNib  = cnt[NIB_W-1:0];
  assign holdNib = hold;
  assign irqReq  = irqQ;

  // R1: prescaler frozen while the clock is gated
  a_r1_presc_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.prescStep && !strobe.clrAll) |=> $stable(presc));
  // R2: counter holds without a running tick
  a_r2_cnt_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!(strobe.prescStep && strobe.cntRun) && !strobe.clrAll) |=> $stable(cnt));
  // R3: clear empties the counter
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> (cnt == '0 && presc == '0));
  // R4: a low read captures the upper bits
  a_r4_latch_value: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchHi |=> (hold == $past(cnt[CNT_W-1 -: NIB_W])));
  // R5: holding register stays put between low reads
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchHi |=> $stable(hold));
  // R7: interrupt request lasts one cycle and lands on a zero count
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq);
  a_r7_irq_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (cnt == '0));
endmodule

// File: rtl/rtcn_timer.sv
module rtcn_timer
  import rtcn_pkg::*;
#(
  parameter int PRESC_W = 7,
  parameter int CNT_W   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busRd,
  input  logic       busWr,
  input  logic [3:0] busWdata,
  output logic [3:0] busRdata,
  output logic       irqReq
);
  localparam int NIB_W = CNT_W / 2;

  tmrStrobe_t       strobe;
  logic [NIB_W-1:0] lowNib, holdNib;

  rtcn_ctrl #(.NIB_W(NIB_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .lowNib(lowNib), .holdNib(holdNib),
    .busRdata(busRdata), .strobe(strobe)
  );

  rtcn_datapath #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lowNib(lowNib), .holdNib(holdNib), .irqReq(irqReq)
  );
endmodule

// File: tb/sim_rtcn_timer.sv
`timescale 1ns/100ps
module sim_rtcn_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [3:0] busWdata = '0;
  logic [3:0] busRdata;
  logic irqReq;

  int checks = 0, failures = 0, irqPulses = 0;
  bit finished = 0;

  rtcn_timer u0 (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq));

  always #2.5 clk = ~clk;

  // reference model built from the requirements
  logic [6:0] mPresc; logic [7:0] mCnt; logic [3:0] mHold;
  logic [2:0] mCtrl; logic mIrq;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPresc <= 0; mCnt <= 0; mHold <= 0; mCtrl <= 0; mIrq <= 0;
    end else begin
      logic wrC, tk;
      wrC = busWr && busAddr == 2'd2;
      tk  = mCtrl[0] && mPresc == 7'd127;
      if (wrC) mCtrl <= busWdata[2:0];
      if (wrC && busWdata[3]) begin mPresc <= 0; mCnt <= 0; end
      else begin
        if (mCtrl[0]) mPresc <= mPresc + 1'b1;
        if (tk && mCtrl[1]) mCnt <= mCnt + 1'b1;
      end
      mIrq <= mCtrl[2] && tk && mCtrl[1] && mCnt == 8'hFF && !(wrC && busWdata[3]);
      if (busRd && busAddr == 2'd0) mHold <= mCnt[7:4];
    end
  end

  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t q[$];

  function automatic logic [3:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return mCnt[3:0];
      2'd1: return mHold;
      2'd2: return {1'b0, mCtrl};
      default: return 4'd0;
    endcase
  endfunction

  task automatic doRead(input logic [1:0] a, input string tag);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    q.push_back('{modelRead(a), tag});
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic doWrite(input logic [3:0] d);
    @(negedge clk);
    busAddr = 2'd2; busWr = 1'b1; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads, watches the interrupt line
  always begin
    @(negedge clk); #1;
    if (busRd && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(busRdata === it.exp, it.tag, busRdata, it.exp);
    end
    if (rstN && (irqReq || mIrq)) begin
      check(irqReq === mIrq, "R7 irq line", irqReq, mIrq);
      if (irqReq) irqPulses++;
    end
  end

  task automatic waitCnt(input logic [7:0] v);
    while (mCnt != v) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    doRead(2'd2, "R6 reset ctrl");
    doRead(2'd0, "R4 reset low");
    doRead(2'd1, "R5 reset hold");
    check(irqReq === 1'b0, "R6 reset irq", irqReq, 0);
    doRead(2'd3, "R6 unused addr");

    doWrite(4'b0001);                 // clock on, stopped
    repeat (300) @(negedge clk);
    doRead(2'd0, "R2 stopped count");
    doRead(2'd2, "R6 ctrl readback");

    doWrite(4'b0011);                 // run
    repeat (1000) @(negedge clk);
    doRead(2'd0, "R1 counting");
    check(mCnt != 0, "R1 model advanced", mCnt, 1);

    doWrite(4'b0010);                 // clock gated
    repeat (500) @(negedge clk);
    doRead(2'd0, "R1 gated frozen");
    doWrite(4'b0011);
    repeat (400) @(negedge clk);
    doRead(2'd0, "R2 resume");

    doWrite(4'b1011);                 // clear, keep running
    waitCnt(8'h0F);
    doRead(2'd0, "R4 low before carry");
    waitCnt(8'h10);
    doRead(2'd1, "R5 hold across carry");
    check(mHold == 4'h0, "R5 model hold old", mHold, 0);
    doRead(2'd0, "R4 low after carry");
    doRead(2'd1, "R5 hold updated");

    doWrite(4'b1011);
    doRead(2'd0, "R3 cleared low");
    doRead(2'd1, "R3 hold kept");
    doRead(2'd2, "R3 clear bit reads 0");

    waitCnt(8'hFF); waitCnt(8'h00); repeat (3) @(negedge clk);
    check(irqPulses == 0, "R7 masked wrap", irqPulses, 0);
    doWrite(4'b0111);
    waitCnt(8'hFF); waitCnt(8'h00); repeat (3) @(negedge clk);
    check(irqPulses == 1, "R7 enabled wrap", irqPulses, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule